// File: doc/BRIEF.md
# AXI Decode-Error Responder

This block is a terminating AXI4 slave for transactions whose address matched nothing in an interconnect's address map. It accepts every request it is given and answers with a decode-error response of the correct shape. A write burst is fully drained before its single write response is issued. A read burst gets as many data beats as its length field asks for, and each beat carries a fixed signature word.

It handles one write and one read at a time. The write path and the read path are independent, so a read burst can proceed while a write is being drained or answered. An interconnect instantiates one of these per upstream port and steers unmapped traffic to it. The ID of each response is the ID taken from the request that started it.

Top module: `decerr_responder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `aw_ready` and `ar_ready` are 1 and `w_ready`, `b_valid` and `r_valid` are 0.
- R2: Every write response and every read beat carries response code 2'b11 (decode error) on `b_resp` / `r_resp`.
- R3: A read accepted with length field L produces exactly L+1 R beats. `r_last` is 1 on the final beat only, and `r_valid` is 0 in the cycle after that beat's handshake.
- R4: `r_data` is the 32-bit word 0xBADCAB1E, zero-extended to DATA_W when DATA_W is above 32 and truncated to its low DATA_W bits when DATA_W is below 32.
- R5: `b_valid` rises only in the cycle after the W beat with `w_last`=1 is accepted. `w_ready` is 0 whenever no write address is pending, so W beats that arrive without an AW are not consumed.
- R6: `b_id` equals the `aw_id` of the accepted AW, and `r_id` equals the `ar_id` of the accepted AR. IDs offered on the address channels while a transaction is in progress have no effect.
- R7: `ar_ready` is 0 from the AR handshake until the final R handshake. `aw_ready` is 0 from the AW handshake until the B handshake.
- R8: Once `b_valid` or `r_valid` is high without its ready, the valid signal and its payload stay unchanged in the next cycle.
- R9: An AR and an AW offered in the same cycle are both accepted. The read burst and the write drain/response then progress concurrently without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_id | input | ID_W | Write transaction ID |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_last | input | 1 | Final write beat of the burst |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | output | ID_W | Write response ID |
| b_resp | output | 2 | Write response code |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_id | input | ID_W | Read transaction ID |
| ar_len | input | LEN_W | Read burst length minus one |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | output | ID_W | Read data ID |
| r_data | output | DATA_W | Read data signature word |
| r_resp | output | 2 | Read response code |
| r_last | output | 1 | Final read beat |

## Verification
A read burst and a write transaction can be in flight together. The AR and AW handshakes can occur on the same edge, and R beats can interleave with W beats and the B response. The bench starts a read task and a write task in parallel from the same clock edge, with back-pressure on both sides. It then judges each path against its own expected beat count, ID, signature and response code. Any coupling between the two state machines would show as a wrong ID, a missing or extra beat, or a stalled handshake.

// File: rtl/decerr_responder.sv
module decerr_responder #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic              w_last,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [ID_W-1:0]   b_id,
  output logic [1:0]        b_resp,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [LEN_W-1:0]  ar_len,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [ID_W-1:0]   r_id,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  output logic              r_last
);

  localparam logic [31:0] SIGNATURE = 32'hBADCAB1E;
  localparam logic [1:0]  DECERR    = 2'b11;

  typedef enum logic [1:0] {WR_ADDR, WR_DATA, WR_RESP} wr_state_t;

  wr_state_t        wr_state;
  logic [ID_W-1:0]  wr_id_q;
  logic             rd_busy;
  logic [LEN_W-1:0] rd_left;
  logic [ID_W-1:0]  rd_id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_state <= WR_ADDR;
      wr_id_q  <= '0;
    end else begin
      case (wr_state)
        WR_ADDR: if (aw_valid) begin
          wr_id_q  <= aw_id;
          wr_state <= WR_DATA;
        end
        WR_DATA: if (w_valid && w_last) wr_state <= WR_RESP;
        WR_RESP: if (b_ready) wr_state <= WR_ADDR;
        default: wr_state <= WR_ADDR;
      endcase
    end
  end

  assign aw_ready = (wr_state == WR_ADDR);
  assign w_ready  = (wr_state == WR_DATA);
  assign b_valid  = (wr_state == WR_RESP);
  assign b_id     = wr_id_q;
  assign b_resp   = DECERR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_busy <= 1'b0;
      rd_left <= '0;
      rd_id_q <= '0;
    end else if (!rd_busy) begin
      if (ar_valid) begin
        rd_busy <= 1'b1;
        rd_left <= ar_len;
        rd_id_q <= ar_id;
      end
    end else if (r_ready) begin
      if (rd_left == '0) rd_busy <= 1'b0;
      else               rd_left <= rd_left - 1'b1;
    end
  end

  assign ar_ready = !rd_busy;
  assign r_valid  = rd_busy;
  assign r_last   = rd_busy && (rd_left == '0);
  assign r_id     = rd_id_q;
  assign r_resp   = DECERR;
  assign r_data   = DATA_W'(SIGNATURE);

endmodule

// File: rtl/decerr_responder_chk.sv
module decerr_responder_chk #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              aw_valid,
  input logic              aw_ready,
  input logic [ID_W-1:0]   aw_id,
  input logic              w_valid,
  input logic              w_ready,
  input logic              w_last,
  input logic              b_valid,
  input logic              b_ready,
  input logic [ID_W-1:0]   b_id,
  input logic [1:0]        b_resp,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [ID_W-1:0]   ar_id,
  input logic [LEN_W-1:0]  ar_len,
  input logic              r_valid,
  input logic              r_ready,
  input logic [ID_W-1:0]   r_id,
  input logic [DATA_W-1:0] r_data,
  input logic [1:0]        r_resp,
  input logic              r_last
);

  localparam logic [DATA_W-1:0] EXP_DATA = DATA_W'(32'hBADCAB1E);

  logic [LEN_W-1:0] beats_left;
  logic [ID_W-1:0]  seen_ar_id;
  logic [ID_W-1:0]  seen_aw_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats_left <= '0;
      seen_ar_id <= '0;
      seen_aw_id <= '0;
    end else begin
      if (ar_valid && ar_ready) begin
        beats_left <= ar_len;
        seen_ar_id <= ar_id;
      end else if (r_valid && r_ready && beats_left != '0) begin
        beats_left <= beats_left - 1'b1;
      end
      if (aw_valid && aw_ready) seen_aw_id <= aw_id;
    end
  end

  assert_rlast_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> (r_last == (beats_left == '0)));
  assert_rdata_sig_R4: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> (r_data == EXP_DATA && r_resp == 2'b11));
  assert_bresp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> b_resp == 2'b11);
  assert_b_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_valid) |-> $past(w_valid && w_ready && w_last));
  assert_rid_echo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> r_id == seen_ar_id);
  assert_bid_echo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> b_id == seen_aw_id);
  assert_ar_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> !ar_ready);
  assert_aw_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ready || b_valid) |-> !aw_ready);
  assert_b_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> (b_valid && $stable(b_id)));
  assert_r_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_id) && $stable(r_last)));

endmodule

bind decerr_responder decerr_responder_chk #(
  .ID_W(ID_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
) i_chk (.*);

// File: tb/test_decerr_responder.sv
module test_decerr_responder;
  localparam int ID_W = 4, DATA_W = 64, LEN_W = 8;
  localparam logic [63:0] SIG64 = 64'h00000000BADCAB1E;

  logic clk = 1'b0, rst_n = 1'b0;
  logic aw_valid = 0, w_valid = 0, w_last = 0, b_ready = 0;
  logic ar_valid = 0, r_ready = 0;
  logic [ID_W-1:0] aw_id = '0, ar_id = '0;
  logic [LEN_W-1:0] ar_len = '0;
  logic aw_ready, w_ready, b_valid, ar_ready, r_valid, r_last;
  logic [ID_W-1:0] b_id, r_id;
  logic [1:0] b_resp, r_resp;
  logic [DATA_W-1:0] r_data;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  decerr_responder #(.ID_W(ID_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) i_decerr_responder (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_len(ar_len),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data),
    .r_resp(r_resp), .r_last(r_last)
  );

  // {is_read, id, len}
  localparam logic [12:0] VEC [8] = '{
    {1'b1, 4'h3, 8'd0},  {1'b0, 4'h5, 8'd0},
    {1'b1, 4'hA, 8'd3},  {1'b0, 4'hC, 8'd4},
    {1'b1, 4'hF, 8'd255},{1'b0, 4'h1, 8'd15},
    {1'b1, 4'h0, 8'd7},  {1'b0, 4'h9, 8'd1}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [ID_W-1:0] id, input logic [LEN_W-1:0] len, input bit stall);
    int beats = 0;
    int cyc = 0;
    @(negedge clk);
    chk(ar_ready === 1'b1, "R7 ar_ready when idle", ar_ready, 1);
    ar_valid = 1; ar_id = id; ar_len = len;
    @(negedge clk);
    ar_valid = stall; ar_id = ~id; ar_len = 8'd9;
    while (beats <= int'(len)) begin
      r_ready = stall ? cyc[0] : 1'b1;
      chk(r_valid === 1'b1, "R3 r_valid in burst", r_valid, 1);
      chk(ar_ready === 1'b0, "R7 ar_ready in burst", ar_ready, 0);
      chk(r_id === id, "R6 r_id echo", r_id, id);
      chk(r_data === SIG64, "R4 r_data signature", r_data, SIG64);
      chk(r_resp === 2'b11, "R2 r_resp", r_resp, 2'b11);
      chk(r_last === (beats == int'(len)), "R3 r_last position", r_last, beats == int'(len));
      if (r_ready) beats++;
      cyc++;
      @(negedge clk);
    end
    r_ready = 0; ar_valid = 0;
    chk(r_valid === 1'b0, "R3 no extra beat", r_valid, 0);
    chk(ar_ready === 1'b1, "R7 ar_ready after burst", ar_ready, 1);
  endtask

  task automatic do_write(input logic [ID_W-1:0] id, input logic [LEN_W-1:0] len, input bit stall);
    int beats = 0;
    int cyc = 0;
    @(negedge clk);
    chk(aw_ready === 1'b1, "R7 aw_ready when idle", aw_ready, 1);
    aw_valid = 1; aw_id = id;
    @(negedge clk);
    aw_valid = stall; aw_id = ~id;
    while (beats <= int'(len)) begin
      w_valid = stall ? cyc[0] : 1'b1;
      w_last  = (beats == int'(len));
      chk(w_ready === 1'b1, "R5 w_ready while draining", w_ready, 1);
      chk(b_valid === 1'b0, "R5 no B before last", b_valid, 0);
      chk(aw_ready === 1'b0, "R7 aw_ready while draining", aw_ready, 0);
      if (w_valid) beats++;
      cyc++;
      @(negedge clk);
    end
    w_valid = 0; w_last = 0;
    chk(b_valid === 1'b1, "R5 B after last", b_valid, 1);
    chk(w_ready === 1'b0, "R5 w_ready after last", w_ready, 0);
    chk(b_id === id, "R6 b_id echo", b_id, id);
    chk(b_resp === 2'b11, "R2 b_resp", b_resp, 2'b11);
    @(negedge clk);
    chk(b_valid === 1'b1 && b_id === id, "R8 B held", {b_valid, b_id}, {1'b1, id});
    chk(aw_ready === 1'b0, "R7 aw_ready before B handshake", aw_ready, 0);
    b_ready = 1;
    @(negedge clk);
    b_ready = 0; aw_valid = 0;
    chk(b_valid === 1'b0, "R5 single B", b_valid, 0);
    chk(aw_ready === 1'b1, "R7 aw_ready after B", aw_ready, 1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    @(negedge clk);
    chk({aw_ready, ar_ready, w_ready, b_valid, r_valid} === 5'b11000, "R1 in reset",
        {aw_ready, ar_ready, w_ready, b_valid, r_valid}, 5'b11000);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({aw_ready, ar_ready, w_ready, b_valid, r_valid} === 5'b11000, "R1 after reset",
        {aw_ready, ar_ready, w_ready, b_valid, r_valid}, 5'b11000);

    for (int i = 0; i < 8; i++) begin
      if (VEC[i][12]) do_read(VEC[i][11:8], VEC[i][7:0], i[1]);
      else            do_write(VEC[i][11:8], VEC[i][7:0], i[1]);
    end

    // R5: W beats without a pending AW are not consumed
    w_valid = 1; w_last = 1;
    repeat (3) begin
      @(negedge clk);
      chk(w_ready === 1'b0, "R5 stray W refused", w_ready, 0);
      chk(b_valid === 1'b0, "R5 stray W gives no B", b_valid, 0);
    end
    w_valid = 0; w_last = 0;

    // R9: AR and AW in the same cycle, both paths under back-pressure
    fork
      do_read(4'h6, 8'd5, 1'b1);
      do_write(4'hB, 8'd3, 1'b1);
    join
    fork
      do_read(4'h2, 8'd2, 1'b0);
      do_write(4'hE, 8'd6, 1'b0);
    join
    chk(aw_ready === 1'b1 && ar_ready === 1'b1, "R9 both idle after overlap",
        {aw_ready, ar_ready}, 2'b11);

    finish_run();
  end
endmodule